// File: doc/BRIEF.md
# Serial Signed Multiply-Accumulate Unit

This unit evaluates one output of a short filter at a time. It works through a fixed number of taps. For each tap it multiplies a 12-bit two's-complement sample by an 8-bit two's-complement coefficient. The multiplication runs one coefficient bit per cycle using shift-and-add, and the partial products go straight into a wide accumulator. One adder does both the multiply and the accumulate. The partial product for the coefficient's most significant bit is subtracted rather than added, so that bit carries its negative weight. When every tap has been processed, a fixed slice of the accumulator is presented as the 12-bit result, together with a one-cycle done strobe.

Coefficients arrive as a serial bit stream and are held in an internal shift chain that serves as the coefficient file. Samples are not stored here. The unit drives a tap index, and the surrounding logic returns the matching sample in the same cycle.

A step counter sequences each computation. It is split into a tap slot and a phase within that slot, and it decodes a fixed pattern of strobes. Each computation occupies exactly one frame of `FRAME` cycles, whatever the data.

Top module: `serial_mac_unit`

## Requirements
- R1: After reset, `done` is low and `result` is zero.
- R2: A coefficient bit is shifted in only on a cycle where `coefValid` is high. After `NTAPS*COEF_W` such bits, the first bit sent is the MSB of tap 0 and the last bit sent is the LSB of tap `NTAPS-1`. Bits of each tap are sent MSB first, and the taps are sent in order from 0 upward.
- R3: `coefValid` has no effect while a computation is in progress. The coefficients used afterwards are those loaded before the computation started.
- R4: A `start` pulse while idle begins a computation. `done` is then high for exactly one cycle, `FRAME` cycles after the clock edge that sampled `start`.
- R5: A `start` pulse during a computation is ignored. It neither restarts the computation nor produces an extra `done`.
- R6: `result` equals bits `[OUT_SHIFT+DATA_W-1:OUT_SHIFT]` of the exact two's-complement sum over taps k of `sample(k)*coef(k)`. Bits above this slice are dropped, so the value wraps.
- R7: A coefficient of -128 (MSB alone set) is weighted as -128 and not as +128.
- R8: Samples at the negative extreme (-2048) are multiplied correctly with sign extension.
- R9: The accumulator is cleared at the start of every computation, so a repeated computation on the same inputs gives the same result.
- R10: `result` holds its value between `done` pulses.
- R11: `sample(k)` is the value on `sampleData` while `sampleAddr` equals k. Tap k is fetched in slot k of the frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| coefValid | input | 1 | Qualifies `coefBit` |
| coefBit | input | 1 | Serial coefficient bit |
| start | input | 1 | Begin one computation (when idle) |
| sampleAddr | output | $clog2(NTAPS) | Tap index whose sample is requested |
| sampleData | input | DATA_W | Sample for `sampleAddr`, same cycle |
| result | output | DATA_W | Scaled, truncated sum |
| done | output | 1 | One-cycle strobe marking a new `result` |

## Verification
The bench keeps the default tap count, widths and frame length. It overrides `OUT_SHIFT` to 5, which places low-order product bits in the visible slice and makes wraparound of large sums easy to reach. Single-tap coefficient patterns isolate the ordering of the coefficient chain and the tap addressing. Extreme operands (-128, -2048) exercise the subtracted MSB partial product and the sign extension.

// File: rtl/serial_mac_pkg.sv
package serial_mac_pkg;

  typedef struct packed {
    logic clearAcc;
    logic loadOps;
    logic addStep;
    logic lastBit;
    logic capture;
    logic busy;
  } macCtrl_t;

endpackage

// File: rtl/serial_mac_ctrl.sv
module serial_mac_ctrl
  import serial_mac_pkg::*;
#(
  parameter int NTAPS  = 7,
  parameter int COEF_W = 8,
  parameter int FRAME  = 128,
  localparam int STEP_W = $clog2(FRAME),
  localparam int SLOT_W = $clog2(COEF_W + 1),
  localparam int TIDX_W = STEP_W - SLOT_W,
  localparam int TAP_W  = $clog2(NTAPS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  output logic [TAP_W-1:0] tapSel,
  output macCtrl_t         strobes
);

  logic              busy;
  logic [STEP_W-1:0] step;
  logic [TIDX_W-1:0] tapIdx;
  logic [SLOT_W-1:0] phase;
  logic              inTap;

  assign tapIdx = step[STEP_W-1:SLOT_W];
  assign phase  = step[SLOT_W-1:0];
  assign tapSel = TAP_W'(tapIdx);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy <= 1'b0;
      step <= '0;
    end else if (!busy) begin
      step <= '0;
      if (start) busy <= 1'b1;
    end else begin
      if (step == STEP_W'(FRAME - 1)) busy <= 1'b0;
      step <= step + 1'b1;
    end
  end

  always_comb begin
    inTap            = busy && (int'(tapIdx) < NTAPS);
    strobes.clearAcc = start && !busy;
    strobes.loadOps  = inTap && (phase == '0);
    strobes.addStep  = inTap && (phase != '0) && (int'(phase) <= COEF_W);
    strobes.lastBit  = inTap && (int'(phase) == COEF_W);
    strobes.capture  = busy && (step == STEP_W'(FRAME - 1));
    strobes.busy     = busy;
  end

  AST_START_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy) |=> (busy && step == '0)); // R4
  AST_IGNORE_START: assert property (@(posedge clk) disable iff (!rstN)
    (start && busy && step != STEP_W'(FRAME - 1)) |=> (busy && step == $past(step) + 1'b1)); // R5

endmodule

// File: rtl/serial_mac_datapath.sv
module serial_mac_datapath
  import serial_mac_pkg::*;
#(
  parameter int DATA_W    = 12,
  parameter int COEF_W    = 8,
  parameter int NTAPS     = 7,
  parameter int OUT_SHIFT = 7,
  localparam int ACC_W    = DATA_W + COEF_W + $clog2(NTAPS),
  localparam int CHAIN_W  = NTAPS * COEF_W,
  localparam int TAP_W    = $clog2(NTAPS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  macCtrl_t          strobes,
  input  logic [TAP_W-1:0]  tapSel,
  input  logic              coefValid,
  input  logic              coefBit,
  input  logic [DATA_W-1:0] sampleData,
  output logic [DATA_W-1:0] result,
  output logic              done
);

  logic [CHAIN_W-1:0] coefChain;
  logic [COEF_W-1:0]  coefTap [NTAPS];
  logic [COEF_W-1:0]  coefSel;
  logic [COEF_W-1:0]  coefSh;
  logic [ACC_W-1:0]   mcand;
  logic [ACC_W-1:0]   acc;
  logic [ACC_W-1:0]   addend;
  logic [ACC_W-1:0]   sum;

  for (genvar k = 0; k < NTAPS; k++) begin : gTap
    assign coefTap[k] = coefChain[(NTAPS-k)*COEF_W-1 -: COEF_W];
  end

  assign coefSel = (int'(tapSel) < NTAPS) ? coefTap[tapSel] : '0;

  // One adder: add for ordinary bits, subtract (invert, carry in) for the MSB.
  assign addend = strobes.lastBit ? ~mcand : mcand;
  assign sum    = acc + addend + ACC_W'(strobes.lastBit);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      coefChain <= '0;
    end else if (coefValid && !strobes.busy) begin
      coefChain <= {coefChain[CHAIN_W-2:0], coefBit};
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      acc    <= '0;
      mcand  <= '0;
      coefSh <= '0;
      result <= '0;
      done   <= 1'b0;
    end else begin
      done <= strobes.capture;
      if (strobes.clearAcc) acc <= '0;
      if (strobes.loadOps) begin
        mcand  <= {{(ACC_W-DATA_W){sampleData[DATA_W-1]}}, sampleData};
        coefSh <= coefSel;
      end
      if (strobes.addStep) begin
        if (coefSh[0]) acc <= sum;
        mcand  <= mcand << 1;
        coefSh <= coefSh >> 1;
      end
      if (strobes.capture) result <= acc[OUT_SHIFT+DATA_W-1:OUT_SHIFT];
    end
  end

  AST_CLEAR_ACC: assert property (@(posedge clk) disable iff (!rstN)
    strobes.clearAcc |=> (acc == '0)); // R9
  AST_BITS_USED: assert property (@(posedge clk) disable iff (!rstN)
    strobes.lastBit |=> (coefSh == '0)); // R6
  AST_COEF_LOCK: assert property (@(posedge clk) disable iff (!rstN)
    strobes.busy |=> $stable(coefChain)); // R3
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R4
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !done |-> $stable(result)); // R10

endmodule

// File: rtl/serial_mac_unit.sv
module serial_mac_unit
  import serial_mac_pkg::*;
#(
  parameter int DATA_W    = 12,
  parameter int COEF_W    = 8,
  parameter int NTAPS     = 7,
  parameter int FRAME     = 128,
  parameter int OUT_SHIFT = 7,
  localparam int TAP_W    = $clog2(NTAPS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              coefValid,
  input  logic              coefBit,
  input  logic              start,
  output logic [TAP_W-1:0]  sampleAddr,
  input  logic [DATA_W-1:0] sampleData,
  output logic [DATA_W-1:0] result,
  output logic              done
);

  macCtrl_t strobes;

  serial_mac_ctrl #(
    .NTAPS(NTAPS), .COEF_W(COEF_W), .FRAME(FRAME)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .start(start),
    .tapSel(sampleAddr), .strobes(strobes)
  );

  serial_mac_datapath #(
    .DATA_W(DATA_W), .COEF_W(COEF_W), .NTAPS(NTAPS), .OUT_SHIFT(OUT_SHIFT)
  ) uPath (
    .clk(clk), .rstN(rstN), .strobes(strobes), .tapSel(sampleAddr),
    .coefValid(coefValid), .coefBit(coefBit), .sampleData(sampleData),
    .result(result), .done(done)
  );

endmodule

// File: tb/serial_mac_unit_test.sv
`timescale 1ns/1ps
module serial_mac_unit_test;
  localparam int DW = 12;
  localparam int CW = 8;
  localparam int NT = 7;
  localparam int FR = 128;
  localparam int OS = 5;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic coefValid = 1'b0;
  logic coefBit = 1'b0;
  logic start = 1'b0;
  logic [2:0] sampleAddr;
  logic [DW-1:0] sampleData;
  logic [DW-1:0] result;
  logic done;

  logic [DW-1:0] smem [NT];
  logic [CW-1:0] coefs [NT];

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int doneSeen = 0;
  int lastExp = 0;
  bit finished = 1'b0;

  int expVal [$];
  int expCyc [$];
  string expTag [$];

  assign sampleData = (int'(sampleAddr) < NT) ? smem[sampleAddr] : '0;

  serial_mac_unit #(.DATA_W(DW), .COEF_W(CW), .NTAPS(NT), .FRAME(FR), .OUT_SHIFT(OS)) uut (
    .clk(clk), .rstN(rstN), .coefValid(coefValid), .coefBit(coefBit), .start(start),
    .sampleAddr(sampleAddr), .sampleData(sampleData), .result(result), .done(done)
  );

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int model();
    longint s = 0;
    for (int k = 0; k < NT; k++)
      s += longint'($signed(smem[k])) * longint'($signed(coefs[k]));
    return int'((s >>> OS) & 64'hFFF);
  endfunction

  // Monitor: pops the scoreboard whenever the design signals a result.
  always @(negedge clk) begin
    if (rstN && done) begin
      if (expVal.size() == 0) begin
        check(1'b0, "R4/R5 unexpected done", 1, 0);
      end else begin
        int ev, ec;
        string tg;
        ev = expVal.pop_front();
        ec = expCyc.pop_front();
        tg = expTag.pop_front();
        check(int'(result) == ev, tg, int'(result), ev);
        check(cyc == ec, "R4 done latency", cyc, ec);
        lastExp = ev;
      end
      doneSeen++;
    end
  end

  task automatic loadCoefs();
    for (int k = 0; k < NT; k++) begin
      for (int b = CW - 1; b >= 0; b--) begin
        @(negedge clk);
        coefValid = 1'b1;
        coefBit = coefs[k][b];
        if (b == 3) begin
          @(negedge clk);
          coefValid = 1'b0;
          coefBit = 1'b1; // R2: junk while not valid
        end
      end
    end
    @(negedge clk);
    coefValid = 1'b0;
  endtask

  task automatic pulseStart(string tag);
    @(negedge clk);
    expVal.push_back(model());
    expCyc.push_back(cyc + 1 + FR);
    expTag.push_back(tag);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic waitDone();
    int t;
    t = doneSeen;
    while (doneSeen == t) @(negedge clk);
  endtask

  task automatic runFrame(string tag);
    pulseStart(tag);
    waitDone();
  endtask

  initial begin
    for (int k = 0; k < NT; k++) begin
      smem[k] = '0;
      coefs[k] = '0;
    end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(done == 1'b0, "R1 done after reset", int'(done), 0);
    check(result == '0, "R1 result after reset", int'(result), 0);

    // R2 / R11: single-tap coefficient picks one sample
    smem[0] = 12'd101; smem[1] = 12'd202; smem[2] = 12'd303; smem[3] = 12'd404;
    smem[4] = 12'd505; smem[5] = 12'd606; smem[6] = 12'd707;
    coefs[0] = 8'd32;
    loadCoefs();
    runFrame("R2 R11 tap0 only");
    coefs[0] = 8'd0; coefs[6] = 8'd32;
    loadCoefs();
    runFrame("R2 R11 tap6 only");
    coefs[6] = 8'd0; coefs[3] = 8'd1;
    loadCoefs();
    runFrame("R2 R11 tap3 low bit");

    // R6: mixed signs
    coefs[0] = 8'd17; coefs[1] = 8'(-3); coefs[2] = 8'd100; coefs[3] = 8'(-77);
    coefs[4] = 8'd5; coefs[5] = 8'd64; coefs[6] = 8'(-128);
    smem[0] = 12'd100; smem[1] = 12'(-200); smem[2] = 12'd2047; smem[3] = 12'(-2048);
    smem[4] = 12'd555; smem[5] = 12'(-1); smem[6] = 12'd7;
    loadCoefs();
    runFrame("R6 mixed");

    // R7: all coefficients -128
    for (int k = 0; k < NT; k++) begin
      coefs[k] = 8'h80;
      smem[k] = 12'(k + 1);
    end
    loadCoefs();
    runFrame("R7 coef -128");

    // R8: extreme negative samples
    for (int k = 0; k < NT; k++) begin
      smem[k] = 12'h800;
      coefs[k] = (k % 2 == 0) ? 8'd127 : 8'(-5);
    end
    loadCoefs();
    runFrame("R8 sample -2048");
    runFrame("R9 repeat same inputs");

    // R5: start during busy
    smem[2] = 12'd999;
    pulseStart("R5 restart ignored");
    repeat (40) @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    waitDone();
    begin
      int d0;
      d0 = doneSeen;
      repeat (FR + 10) @(negedge clk);
      check(doneSeen == d0, "R5 no extra done", doneSeen, d0);
    end

    // R10: result holds
    repeat (20) @(negedge clk);
    check(int'(result) == lastExp, "R10 result holds", int'(result), lastExp);

    // R3: coefficient shifting during busy ignored
    pulseStart("R3 load during busy");
    repeat (10) @(negedge clk);
    for (int i = 0; i < 16; i++) begin
      coefValid = 1'b1;
      coefBit = i[0];
      @(negedge clk);
    end
    coefValid = 1'b0;
    waitDone();
    runFrame("R3 coefficients unchanged");

    // R6: pseudo-random frames
    begin
      int seed;
      seed = 12345;
      for (int f = 0; f < 4; f++) begin
        for (int k = 0; k < NT; k++) begin
          seed = seed * 1103515245 + 12345;
          smem[k] = 12'(seed >>> 8);
          seed = seed * 1103515245 + 12345;
          coefs[k] = 8'(seed >>> 12);
        end
        loadCoefs();
        runFrame("R6 random");
      end
    end

    repeat (5) @(negedge clk);
    check(expVal.size() == 0, "R4 all results seen", expVal.size(), 0);
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule